// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of eight DMA channels is served next when more than one of them asks for the bus at the same time. Each cycle it looks at the request vector and at the priority order in force. When no grant is outstanding it picks the highest-ranked requesting channel and registers a one-hot grant. That grant stays in place until the transfer engine pulses `unit_done` to say that one transfer unit has finished.

Three orderings are available. The first is plain numeric order. The second interleaves the lower and upper halves of the channel set. The third is a rotating order: the channel that has just completed a unit drops to the bottom of the list, and all the other channels keep their relative positions. The rotating order is kept as a queue of channel numbers. It is updated once per completed unit, never once per block.

All pins are plain control and status pins. No data flows through the block, so there is no valid/ready handshake and no back-pressure. A grant is held until `unit_done` arrives, and a request that is withdrawn during that time does not cancel it.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `mode_sel` is decoded as follows: 2'b00 selects numeric order, 2'b01 selects interleaved order, and 2'b10 or 2'b11 selects rotating order. The mode in force after reset is numeric order.
- R2: In numeric order the lowest-numbered requesting channel wins.
- R3: In interleaved order the channels rank from highest to lowest as 0, 4, 1, 5, 2, 6, 3, 7.
- R4: In rotating order, each completed unit moves the served channel to the lowest position. The other channels keep their relative order.
- R5: The rotating order after reset, and after any switch into rotating mode, is 0 > 1 > 2 > 3 > 4 > 5 > 6 > 7.
- R6: `grant` is one-hot while `grant_valid` is high. It is all zeros and `grant_valid` is low whenever no grant is held, including right after reset and whenever no channel requests.
- R7: A grant holds steady until `unit_done` arrives, even if requests change or are withdrawn. A `unit_done` pulse while no grant is held has no effect on the grant or on the rotating order.
- R8: A grant appears at the clock edge that ends the first idle cycle in which a request is present, and it goes to a channel that was requesting in that cycle. `unit_done` clears the grant at the next edge. The next decision is made in the cycle after that.
- R9: A change of `mode_sel` takes effect only while no grant is held. The change uses up one idle cycle in which nothing is granted. A change made while a grant is held is deferred until that grant ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | One request bit per channel |
| mode_sel | input | 2 | Priority order select (see R1) |
| unit_done | input | 1 | One-cycle pulse: the granted unit has completed |
| grant | output | 8 | One-hot grant, zero when idle |
| grant_valid | output | 1 | High while a grant is held |

## Verification
The assertions make no assumption about `req` or `mode_sel`: both may change at any time. The assertions also accept a `unit_done` pulse in a cycle with no grant. The only expectation is that `unit_done` is a pulse rather than a level. If it were a level, a new grant would be released again immediately after it was issued. The stimulus drives every input on the falling edge. It raises `unit_done` for exactly one cycle per held grant, plus one deliberate pulse while idle. Requests are swept over every non-zero pattern in both fixed orders. A pseudo-random pattern sequence drives the rotating order.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    MODE_FIX_A = 2'b00,
    MODE_FIX_B = 2'b01,
    MODE_RR    = 2'b10
  } dpa_mode_e;

  // Both upper encodings select the rotating order.
  function automatic dpa_mode_e dpa_norm_mode(input logic [1:0] sel);
    if (sel[1]) return MODE_RR;
    return sel[0] ? MODE_FIX_B : MODE_FIX_A;
  endfunction

endpackage

// File: rtl/dpa_rr_queue.sv
module dpa_rr_queue #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reload,
  input  logic                    adv,
  input  logic [IW-1:0]           served_pos,
  output logic [NCH-1:0][IW-1:0]  order
);

  // Slot 0 is the highest rank. On adv the served slot is removed,
  // the slots below it close the gap, and it re-enters at the tail.
  for (genvar s = 0; s < NCH; s++) begin : g_slot
    logic [IW-1:0] nxt;
    if (s == NCH - 1) begin : g_tail
      always_comb begin
        nxt = order[s];
        if (reload)   nxt = IW'(s);
        else if (adv) nxt = order[served_pos];
      end
    end else begin : g_body
      always_comb begin
        nxt = order[s];
        if (reload) nxt = IW'(s);
        else if (adv && (s >= int'(served_pos))) nxt = order[s+1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) order[s] <= IW'(s);
      else        order[s] <= nxt;
    end
  end

  logic [NCH-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NCH; i++) seen[order[i]] = 1'b1;
  end

  assert_order_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NCH{1'b1}});

  assert_served_to_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload) |=> order[NCH-1] == $past(order[served_pos]));

  assert_reload_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (order[0] == '0) && (order[NCH-1] == IW'(NCH-1)));

endmodule

// File: rtl/dpa_picker.sv
module dpa_picker
  import dpa_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH),
  localparam int HALF = NCH / 2
) (
  input  logic [NCH-1:0]          req,
  input  dpa_mode_e               mode,
  input  logic [NCH-1:0][IW-1:0]  order,
  output logic                    hit,
  output logic [IW-1:0]           win_id,
  output logic [IW-1:0]           win_pos
);

  // Channel sitting at each rank under the selected mode.
  // The interleaved order assumes an even channel count.
  logic [NCH-1:0][IW-1:0] cand;
  always_comb begin
    for (int p = 0; p < NCH; p++) begin
      unique case (mode)
        MODE_FIX_B: cand[p] = IW'(p / 2 + (p % 2) * HALF);
        MODE_RR:    cand[p] = order[p];
        default:    cand[p] = IW'(p);
      endcase
    end
  end

  // Scan from the lowest rank upwards so the highest rank wins.
  always_comb begin
    hit     = 1'b0;
    win_id  = '0;
    win_pos = '0;
    for (int p = NCH - 1; p >= 0; p--) begin
      if (req[cand[p]]) begin
        hit     = 1'b1;
        win_id  = cand[p];
        win_pos = IW'(p);
      end
    end
  end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dpa_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [1:0]     mode_sel,
  input  logic           unit_done,
  output logic [NCH-1:0] grant,
  output logic           grant_valid
);

  dpa_mode_e              mode_q;
  dpa_mode_e              mode_in;
  logic                   busy;
  logic [NCH-1:0]         grant_q;
  logic [IW-1:0]          gpos_q;
  logic [NCH-1:0][IW-1:0] order;
  logic                   hit;
  logic [IW-1:0]          win_id;
  logic [IW-1:0]          win_pos;
  logic                   mode_chg;
  logic                   take;
  logic                   finish;

  assign mode_in  = dpa_norm_mode(mode_sel);
  assign mode_chg = !busy && (mode_in != mode_q);
  assign take     = !busy && !mode_chg && hit;
  assign finish   = busy && unit_done;

  dpa_rr_queue #(.NCH(NCH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (mode_chg && (mode_in == MODE_RR)),
    .adv        (finish && (mode_q == MODE_RR)),
    .served_pos (gpos_q),
    .order      (order)
  );

  dpa_picker #(.NCH(NCH)) u_pick (
    .req     (req),
    .mode    (mode_q),
    .order   (order),
    .hit     (hit),
    .win_id  (win_id),
    .win_pos (win_pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_FIX_A;
      busy    <= 1'b0;
      grant_q <= '0;
      gpos_q  <= '0;
    end else begin
      if (mode_chg) mode_q <= mode_in;
      if (take) begin
        busy    <= 1'b1;
        grant_q <= NCH'(1) << win_id;
        gpos_q  <= win_pos;
      end else if (finish) begin
        busy    <= 1'b0;
        grant_q <= '0;
      end
    end
  end

  assign grant       = grant_q;
  assign grant_valid = busy;

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $countones(grant) == 1);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant == '0);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !unit_done) |=> grant_valid && $stable(grant));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && unit_done) |=> !grant_valid);

  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ($past(req) & grant) != '0);

  assert_fixed_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && mode_q == MODE_FIX_A)
      |-> grant == ($past(req) & (~$past(req) + 1'b1)));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> $stable(mode_q));

endmodule

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic [1:0] mode_sel;
  logic       unit_done;
  logic [7:0] grant;
  logic       grant_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int q [8];
  int mcur;

  always #2 clk = ~clk;

  dma_prio_arbiter u_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .mode_sel(mode_sel),
    .unit_done(unit_done), .grant(grant), .grant_valid(grant_valid)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_win(input logic [7:0] r);
    for (int p = 0; p < 8; p++) begin
      int id;
      id = (mcur == 0) ? p : (mcur == 1) ? ((p >> 1) + (p & 1) * 4) : q[p];
      if (r[id]) return id;
    end
    return -1;
  endfunction

  task automatic rr_reload();
    for (int i = 0; i < 8; i++) q[i] = i;
  endtask

  task automatic rr_served(input int id);
    int pos;
    pos = 0;
    for (int i = 0; i < 8; i++) if (q[i] == id) pos = i;
    for (int i = pos; i < 7; i++) q[i] = q[i+1];
    q[7] = id;
  endtask

  // One complete unit: request, grant, hold with requests withdrawn, release.
  task automatic run_unit(input logic [7:0] r, input string tag);
    int e;
    @(negedge clk) req = r;
    @(negedge clk);
    e = exp_win(r);
    req = '0;
    if (e < 0) begin
      chk({tag, " R6 none"}, {grant_valid, grant}, 9'h000);
      return;
    end
    chk(tag, {grant_valid, grant}, {1'b1, 8'(1 << e)});
    @(negedge clk);
    chk("R7 hold", {grant_valid, grant}, {1'b1, 8'(1 << e)});
    unit_done = 1'b1;
    @(negedge clk) unit_done = 1'b0;
    chk("R8 release", {grant_valid, grant}, 9'h000);
    if (mcur == 2) rr_served(e);
  endtask

  task automatic set_mode(input logic [1:0] m);
    int nm;
    @(negedge clk) mode_sel = m;
    nm = m[1] ? 2 : int'(m[0]);
    @(negedge clk);
    if (nm != mcur) chk("R1 R9 switch cycle", {grant_valid, grant}, 9'h000);
    if (nm != mcur && nm == 2) rr_reload();
    mcur = nm;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    int e;
    rst_n = 1'b0; req = '0; mode_sel = 2'b00; unit_done = 1'b0;
    mcur = 0; rr_reload();
    repeat (3) @(negedge clk);
    chk("R6 reset", {grant_valid, grant}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset idle", {grant_valid, grant}, 9'h000);

    // R2: every non-zero pattern in numeric order
    for (int r = 1; r < 256; r++) run_unit(8'(r), "R2 numeric");
    run_unit(8'h00, "R6 empty");

    // R3: interleaved order
    set_mode(2'b01);
    for (int r = 1; r < 256; r++) run_unit(8'(r), "R3 interleaved");

    // R5, R4: rotating order
    set_mode(2'b10);
    run_unit(8'hFF, "R5 rr start");
    lf = 8'hA5;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      run_unit(lf | 8'(k[3:0] == 0 ? 8'h00 : 8'h00), "R4 rr");
    end
    for (int k = 0; k < 8; k++) run_unit(8'hFF, "R4 rr full");

    // R7: unit_done while idle leaves the rotating order untouched
    @(negedge clk) unit_done = 1'b1;
    @(negedge clk) unit_done = 1'b0;
    chk("R7 idle done", {grant_valid, grant}, 9'h000);
    run_unit(8'hFF, "R7 order kept");

    // R9: mode change during a grant is deferred
    @(negedge clk) req = 8'hFF;
    @(negedge clk);
    e = exp_win(8'hFF);
    chk("R9 granted", {grant_valid, grant}, {1'b1, 8'(1 << e)});
    mode_sel = 2'b00; req = '0;
    @(negedge clk);
    chk("R9 deferred", {grant_valid, grant}, {1'b1, 8'(1 << e)});
    unit_done = 1'b1;
    @(negedge clk) unit_done = 1'b0;
    chk("R9 released", {grant_valid, grant}, 9'h000);
    rr_served(e);
    req = 8'h90;
    @(negedge clk);
    chk("R9 switch no grant", {grant_valid, grant}, 9'h000);
    mcur = 0;
    @(negedge clk);
    chk("R9 new mode", {grant_valid, grant}, 9'h110);
    req = '0; unit_done = 1'b1;
    @(negedge clk) unit_done = 1'b0;
    chk("R8 release", {grant_valid, grant}, 9'h000);

    // R5: re-entering rotating mode reloads the start order
    set_mode(2'b11);
    for (int k = 0; k < 5; k++) run_unit(8'hFF, "R5 rr");
    run_unit(8'h81, "R5 rr wrap");
    set_mode(2'b01);
    set_mode(2'b10);
    run_unit(8'hFF, "R5 reload head");
    run_unit(8'h81, "R5 reload order");
    set_mode(2'b11);
    run_unit(8'hC0, "R1 code 11 same mode");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule